// File: doc/BRIEF.md
# Two-wide register rename map with branch recovery

This block is the rename stage of an out-of-order core. Each cycle it takes a group of up to two instructions. Every source operand is translated from an architectural register number to the physical register that holds that register's newest value. Every destination is given a physical register that no instruction in flight is using. Giving each writer its own physical register removes false write-after-write and write-after-read conflicts, so unrelated writers of the same architectural register can be in flight together. The physical pool is larger than the architectural set. At reset, architectural register i sits in physical register i, and the registers above the architectural range form a free pool that is handed out in ascending order.

When a branch is renamed, the block saves the whole map and the pool position into one of a small number of checkpoint slots, and it reports the slot number with the branch. Later, the branch is resolved by naming its slot. If the branch was predicted correctly, the slot is simply released. If it was mispredicted, the map and the pool position return to the saved state in one cycle. The mispredicted slot and every slot taken after it are released. Every physical register handed out on the wrong path then becomes available again.

The group is accepted only when the pool and the free checkpoint slots both cover its needs. Otherwise `ready` drops and the group has no effect.

Top module: `rn_rename_map`

## Requirements
- R1: After reset, architectural register i maps to physical register i, all 32 pool registers (physical 16 to 47) are free, no checkpoint slot is held, and `ready` is high.
- R2: Each accepted instruction with a destination receives physical register 16 plus the number of pool registers currently handed out. Lane 0 is served before lane 1, so two writers in one group always receive different registers.
- R3: Source lookups return the newest physical register of the architectural register. When both lanes of one accepted group write the same architectural register, the lane 1 register becomes the newest.
- R4: When lane 0 is valid and writes a destination, any lane 1 source naming that destination receives lane 0's new physical register, not the older mapping.
- R5: An instruction without a destination takes no pool register, and its `out_dst_phys` is 0.
- R6: `ready` is low whenever the free pool holds fewer registers than the writers in the presented group. A group that is not accepted hands out nothing and changes no mapping.
- R7: A branch receives the lowest free checkpoint slot. When both lanes hold branches, lane 1 receives the next lowest. `ready` is low when fewer slots are free than the group has branches. The slot saves the state after the branch itself, including the branch's own destination and anything earlier in its group.
- R8: On a mispredict for a held slot, the map and pool position equal that slot's saved state from the next cycle on, so the next writer reuses the first register handed out after the branch.
- R9: A mispredict releases its own slot and every slot taken after it. Slots taken before it stay held.
- R10: In a cycle with `res_valid` and `res_mispredict` both high, `ready` is low and the presented group is ignored.
- R11: A correct resolve releases its slot and leaves the map and pool unchanged. It may coincide with renaming of a new group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 2 | Lane holds an instruction |
| in_has_dst | input | 2 | Lane writes a destination |
| in_is_branch | input | 2 | Lane is a branch needing a checkpoint |
| in_dst | input | 2x4 | Destination architectural register per lane |
| in_src_a | input | 2x4 | First source architectural register per lane |
| in_src_b | input | 2x4 | Second source architectural register per lane |
| ready | output | 1 | Group is accepted this cycle |
| out_dst_phys | output | 2x6 | New physical register per lane (0 when no destination) |
| out_src_a_phys | output | 2x6 | Physical register of first source |
| out_src_b_phys | output | 2x6 | Physical register of second source |
| out_br_tag | output | 2x2 | Checkpoint slot given to a branch lane |
| res_valid | input | 1 | A branch resolves this cycle |
| res_tag | input | 2 | Slot of the resolving branch |
| res_mispredict | input | 1 | Resolving branch was mispredicted |

## Verification
A stale or corrupted map entry shows up on the next cycle in which any lane reads that architectural register, as a wrong source physical number. A slipped pool position shows up at the very next accepted writer, as a wrong destination number. A bad checkpoint only appears after its mispredict: the first reads and allocation after recovery disagree with the saved state. Wrong slot bookkeeping appears as wrong tags on later branches, or as a `ready` value that disagrees with the slot count. The bench therefore mixes reads of recently written registers, stalls, nested branches and recoveries, so that each kind of fault is exposed within a few cycles of its cause.

// File: rtl/rn_pkg.sv
package rn_pkg;
    // default geometry of the rename stage
    parameter int DEF_ARCH  = 16;
    parameter int DEF_PHYS  = 48;
    parameter int DEF_CKPT  = 4;
    // group width; lane 1 bypasses from lane 0
    parameter int LANES     = 2;
endpackage

// File: rtl/rn_src_lookup.sv
// One source operand lookup with bypass from an older lane of the same group.
module rn_src_lookup #(
    parameter int ARCH = 16,
    parameter int AW   = 4,
    parameter int PW   = 6
) (
    input  logic [ARCH-1:0][PW-1:0] map_i,
    input  logic [AW-1:0]           arch_i,
    input  logic                    byp_en_i,
    input  logic [AW-1:0]           byp_dst_i,
    input  logic [PW-1:0]           byp_phys_i,
    output logic [PW-1:0]           phys_o
);
    always_comb begin
        if (byp_en_i && (arch_i == byp_dst_i)) begin
            phys_o = byp_phys_i;
        end else begin
            phys_o = map_i[arch_i];
        end
    end
endmodule

// File: rtl/rn_free_pool.sv
// Pool of unused physical registers, handed out in ascending order.
// The position is rewound on recovery.
module rn_free_pool #(
    parameter int POOL = 32,
    parameter int CW   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    take_i,
    input  logic          restore_i,
    input  logic [CW-1:0] restore_ptr_i,
    output logic [CW-1:0] ptr_o,
    output logic [CW-1:0] avail_o
);
    typedef struct packed {
        logic [CW-1:0] ptr;
    } pool_st_t;

    pool_st_t pool_q, pool_d;

    always_comb begin
        pool_d = pool_q;
        if (restore_i) begin
            pool_d.ptr = restore_ptr_i;
        end else begin
            pool_d.ptr = pool_q.ptr + CW'(take_i);
        end
        ptr_o   = pool_q.ptr;
        avail_o = CW'(POOL) - pool_q.ptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pool_q <= '0;
        end else begin
            pool_q <= pool_d;
        end
    end
endmodule

// File: rtl/rn_ckpt_store.sv
// Branch checkpoint slots: saved map, saved pool position and age order.
module rn_ckpt_store #(
    parameter int ARCH  = 16,
    parameter int PW    = 6,
    parameter int CKPTS = 4,
    parameter int TW    = 2,
    parameter int CW    = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take0_i,
    input  logic                    take1_i,
    input  logic [ARCH-1:0][PW-1:0] snap0_map_i,
    input  logic [CW-1:0]           snap0_ptr_i,
    input  logic [ARCH-1:0][PW-1:0] snap1_map_i,
    input  logic [CW-1:0]           snap1_ptr_i,
    input  logic                    res_valid_i,
    input  logic [TW-1:0]           res_tag_i,
    input  logic                    res_misp_i,
    output logic [TW:0]             free_o,
    output logic [TW-1:0]           first_o,
    output logic [TW-1:0]           second_o,
    output logic                    rest_hit_o,
    output logic [ARCH-1:0][PW-1:0] rest_map_o,
    output logic [CW-1:0]           rest_ptr_o
);
    typedef struct packed {
        logic [CKPTS-1:0]                     valid;
        logic [CKPTS-1:0][CKPTS-1:0]          younger;
        logic [CKPTS-1:0][ARCH-1:0][PW-1:0]   map;
        logic [CKPTS-1:0][CW-1:0]             ptr;
    } ck_st_t;

    ck_st_t ck_q, ck_d;
    logic   got_first, got_second;
    logic [TW:0]   used;
    logic [TW-1:0] slot1;

    // lowest two free slots and the count of free slots
    always_comb begin
        got_first  = 1'b0;
        got_second = 1'b0;
        first_o    = '0;
        second_o   = '0;
        used       = '0;
        for (int i = 0; i < CKPTS; i++) begin
            used = used + (TW+1)'(ck_q.valid[i]);
            if (!ck_q.valid[i]) begin
                if (!got_first) begin
                    first_o   = TW'(i);
                    got_first = 1'b1;
                end else if (!got_second) begin
                    second_o   = TW'(i);
                    got_second = 1'b1;
                end
            end
        end
        free_o = (TW+1)'(CKPTS) - used;
    end

    always_comb begin
        rest_hit_o = res_valid_i && res_misp_i && ck_q.valid[res_tag_i];
        rest_map_o = ck_q.map[res_tag_i];
        rest_ptr_o = ck_q.ptr[res_tag_i];
    end

    always_comb begin
        ck_d  = ck_q;
        slot1 = take0_i ? second_o : first_o;
        if (take0_i) begin
            ck_d.valid[first_o]   = 1'b1;
            ck_d.map[first_o]     = snap0_map_i;
            ck_d.ptr[first_o]     = snap0_ptr_i;
            ck_d.younger[first_o] = '0;
            for (int c = 0; c < CKPTS; c++) begin
                ck_d.younger[c][first_o] = ck_q.valid[c];
            end
        end
        if (take1_i) begin
            ck_d.valid[slot1]   = 1'b1;
            ck_d.map[slot1]     = snap1_map_i;
            ck_d.ptr[slot1]     = snap1_ptr_i;
            ck_d.younger[slot1] = '0;
            for (int c = 0; c < CKPTS; c++) begin
                ck_d.younger[c][slot1] = ck_q.valid[c];
            end
            if (take0_i) begin
                ck_d.younger[first_o][slot1] = 1'b1;
            end
        end
        if (res_valid_i && ck_q.valid[res_tag_i]) begin
            if (res_misp_i) begin
                ck_d.valid = ck_q.valid & ~ck_q.younger[res_tag_i];
            end
            ck_d.valid[res_tag_i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_q <= '0;
        end else begin
            ck_q <= ck_d;
        end
    end
endmodule

// File: rtl/rn_rename_map.sv
// Two-wide rename map with checkpoint recovery.
module rn_rename_map
    import rn_pkg::*;
#(
    parameter  int ARCH_REGS  = DEF_ARCH,
    parameter  int PHYS_REGS  = DEF_PHYS,
    parameter  int CKPT_SLOTS = DEF_CKPT,
    localparam int AW   = $clog2(ARCH_REGS),
    localparam int PW   = $clog2(PHYS_REGS),
    localparam int TW   = $clog2(CKPT_SLOTS),
    localparam int POOL = PHYS_REGS - ARCH_REGS,
    localparam int CW   = $clog2(POOL + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES-1:0]          in_valid,
    input  logic [LANES-1:0]          in_has_dst,
    input  logic [LANES-1:0]          in_is_branch,
    input  logic [LANES-1:0][AW-1:0]  in_dst,
    input  logic [LANES-1:0][AW-1:0]  in_src_a,
    input  logic [LANES-1:0][AW-1:0]  in_src_b,
    output logic                      ready,
    output logic [LANES-1:0][PW-1:0]  out_dst_phys,
    output logic [LANES-1:0][PW-1:0]  out_src_a_phys,
    output logic [LANES-1:0][PW-1:0]  out_src_b_phys,
    output logic [LANES-1:0][TW-1:0]  out_br_tag,
    input  logic                      res_valid,
    input  logic [TW-1:0]             res_tag,
    input  logic                      res_mispredict
);
    typedef logic [ARCH_REGS-1:0][PW-1:0] map_t;

    typedef struct packed {
        map_t map;
    } rn_st_t;

    rn_st_t        st_q, st_d;
    logic [CW-1:0] pool_ptr, pool_avail;
    logic [TW:0]   ck_free;
    logic [TW-1:0] ck_first, ck_second;
    logic          rest_hit;
    map_t          rest_map;
    logic [CW-1:0] rest_ptr;
    logic          wr0, wr1, br0, br1;
    logic [1:0]    need_regs, need_ck, take_n;
    logic          recovering, fire;
    logic [PW-1:0] new0, new1;
    map_t          after0, after1;
    logic [CW-1:0] ptr0, ptr1;

    always_comb begin
        wr0        = in_valid[0] && in_has_dst[0];
        wr1        = in_valid[1] && in_has_dst[1];
        br0        = in_valid[0] && in_is_branch[0];
        br1        = in_valid[1] && in_is_branch[1];
        need_regs  = 2'(wr0) + 2'(wr1);
        need_ck    = 2'(br0) + 2'(br1);
        recovering = res_valid && res_mispredict;
        ready      = !recovering
                     && (pool_avail >= CW'(need_regs))
                     && (ck_free >= (TW+1)'(need_ck));
        fire       = ready && (|in_valid);
        take_n     = fire ? need_regs : 2'd0;

        new0 = PW'(ARCH_REGS) + PW'(pool_ptr);
        new1 = new0 + PW'(wr0);
        ptr0 = pool_ptr + CW'(wr0);
        ptr1 = ptr0 + CW'(wr1);

        after0 = st_q.map;
        if (wr0) begin
            after0[in_dst[0]] = new0;
        end
        after1 = after0;
        if (wr1) begin
            after1[in_dst[1]] = new1;
        end

        st_d = st_q;
        if (rest_hit) begin
            st_d.map = rest_map;
        end else if (fire) begin
            st_d.map = after1;
        end

        out_dst_phys[0] = wr0 ? new0 : '0;
        out_dst_phys[1] = wr1 ? new1 : '0;
        out_br_tag[0]   = ck_first;
        out_br_tag[1]   = br0 ? ck_second : ck_first;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH_REGS; i++) begin
                st_q.map[i] <= PW'(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        rn_src_lookup #(.ARCH(ARCH_REGS), .AW(AW), .PW(PW)) u_src_a (
            .map_i      (st_q.map),
            .arch_i     (in_src_a[l]),
            .byp_en_i   ((l > 0) ? wr0 : 1'b0),
            .byp_dst_i  (in_dst[0]),
            .byp_phys_i (new0),
            .phys_o     (out_src_a_phys[l])
        );
        rn_src_lookup #(.ARCH(ARCH_REGS), .AW(AW), .PW(PW)) u_src_b (
            .map_i      (st_q.map),
            .arch_i     (in_src_b[l]),
            .byp_en_i   ((l > 0) ? wr0 : 1'b0),
            .byp_dst_i  (in_dst[0]),
            .byp_phys_i (new0),
            .phys_o     (out_src_b_phys[l])
        );
    end

    rn_free_pool #(.POOL(POOL), .CW(CW)) u_pool (
        .clk           (clk),
        .rst_n         (rst_n),
        .take_i        (take_n),
        .restore_i     (rest_hit),
        .restore_ptr_i (rest_ptr),
        .ptr_o         (pool_ptr),
        .avail_o       (pool_avail)
    );

    rn_ckpt_store #(
        .ARCH(ARCH_REGS), .PW(PW), .CKPTS(CKPT_SLOTS), .TW(TW), .CW(CW)
    ) u_ckpt (
        .clk         (clk),
        .rst_n       (rst_n),
        .take0_i     (fire && br0),
        .take1_i     (fire && br1),
        .snap0_map_i (after0),
        .snap0_ptr_i (ptr0),
        .snap1_map_i (after1),
        .snap1_ptr_i (ptr1),
        .res_valid_i (res_valid),
        .res_tag_i   (res_tag),
        .res_misp_i  (res_mispredict),
        .free_o      (ck_free),
        .first_o     (ck_first),
        .second_o    (ck_second),
        .rest_hit_o  (rest_hit),
        .rest_map_o  (rest_map),
        .rest_ptr_o  (rest_ptr)
    );
endmodule

// File: rtl/rn_rename_chk.sv
// Port-level properties of the rename stage, attached by bind.
module rn_rename_chk #(
    parameter int ARCH_REGS = 16,
    parameter int PHYS_REGS = 48,
    parameter int AW        = 4,
    parameter int PW        = 6,
    parameter int TW        = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          in_valid,
    input logic [1:0]          in_has_dst,
    input logic [1:0]          in_is_branch,
    input logic [1:0][AW-1:0]  in_dst,
    input logic [1:0][AW-1:0]  in_src_a,
    input logic                ready,
    input logic [1:0][PW-1:0]  out_dst_phys,
    input logic [1:0][PW-1:0]  out_src_a_phys,
    input logic [1:0][TW-1:0]  out_br_tag,
    input logic                res_valid,
    input logic                res_mispredict
);
    // R2
    two_writers_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && in_valid[0] && in_has_dst[0] && in_valid[1] && in_has_dst[1]
        |-> out_dst_phys[0] != out_dst_phys[1]);

    // R6
    pool_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && in_valid[0] && in_has_dst[0]
        |-> (out_dst_phys[0] >= PW'(ARCH_REGS)) && (out_dst_phys[0] < PW'(PHYS_REGS - 1) + PW'(1)));

    // R4
    group_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && in_valid[0] && in_has_dst[0] && in_valid[1] && (in_src_a[1] == in_dst[0])
        |-> out_src_a_phys[1] == out_dst_phys[0]);

    // R3
    newest_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && in_valid[0] && in_has_dst[0] && !in_valid[1]
        |=> !(in_valid[0] && (in_src_a[0] == $past(in_dst[0])))
            || (out_src_a_phys[0] == $past(out_dst_phys[0])));

    // R10
    recover_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_mispredict |-> !ready);

    // R7
    branch_tags_differ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && in_valid[0] && in_is_branch[0] && in_valid[1] && in_is_branch[1]
        |-> out_br_tag[0] != out_br_tag[1]);
endmodule

bind rn_rename_map rn_rename_chk #(
    .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .AW(AW), .PW(PW), .TW(TW)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_has_dst     (in_has_dst),
    .in_is_branch   (in_is_branch),
    .in_dst         (in_dst),
    .in_src_a       (in_src_a),
    .ready          (ready),
    .out_dst_phys   (out_dst_phys),
    .out_src_a_phys (out_src_a_phys),
    .out_br_tag     (out_br_tag),
    .res_valid      (res_valid),
    .res_mispredict (res_mispredict)
);

// File: tb/rn_rename_map_tb_top.sv
`timescale 1ns/1ps
module rn_rename_map_tb_top;
    localparam int NA = 16;
    localparam int NC = 4;
    localparam int POOL = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      in_valid = '0, in_has_dst = '0, in_is_branch = '0;
    logic [1:0][3:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic            ready;
    logic [1:0][5:0] out_dst_phys, out_src_a_phys, out_src_b_phys;
    logic [1:0][1:0] out_br_tag;
    logic            res_valid = 1'b0, res_mispredict = 1'b0;
    logic [1:0]      res_tag = '0;

    always #10 clk = ~clk;

    rn_rename_map dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_has_dst(in_has_dst), .in_is_branch(in_is_branch),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .ready(ready), .out_dst_phys(out_dst_phys),
        .out_src_a_phys(out_src_a_phys), .out_src_b_phys(out_src_b_phys),
        .out_br_tag(out_br_tag),
        .res_valid(res_valid), .res_tag(res_tag), .res_mispredict(res_mispredict)
    );

    // behavioural reference
    int m_map[NA];
    int m_ptr;
    bit m_ck_v[NC];
    int m_ck_map[NC][NA];
    int m_ck_ptr[NC];
    int m_order[$];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // staged stimulus
    bit s_v[2], s_d[2], s_b[2];
    int s_dst[2], s_sa[2], s_sb[2];
    bit s_rv, s_rm;
    int s_rt;

    function automatic void model_reset();
        for (int i = 0; i < NA; i++) m_map[i] = i;
        m_ptr = 0;
        for (int i = 0; i < NC; i++) m_ck_v[i] = 0;
        m_order.delete();
    endfunction

    function automatic int lowest_free(int skip);
        for (int i = 0; i < NC; i++) if (!m_ck_v[i] && i != skip) return i;
        return 0;
    endfunction

    function automatic void model_take(int t);
        m_ck_v[t] = 1;
        for (int i = 0; i < NA; i++) m_ck_map[t][i] = m_map[i];
        m_ck_ptr[t] = m_ptr;
        m_order.push_back(t);
    endfunction

    task automatic chk_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_stage();
        for (int l = 0; l < 2; l++) begin
            s_v[l] = 0; s_d[l] = 0; s_b[l] = 0;
            s_dst[l] = 0; s_sa[l] = 0; s_sb[l] = 0;
        end
        s_rv = 0; s_rm = 0; s_rt = 0;
    endtask

    task automatic set_lane(int l, bit d, int dst, int sa, int sb, bit b);
        s_v[l] = 1; s_d[l] = d; s_dst[l] = dst; s_sa[l] = sa; s_sb[l] = sb; s_b[l] = b;
    endtask

    task automatic set_res(int t, bit misp);
        s_rv = 1; s_rt = t; s_rm = misp;
    endtask

    task automatic step(string req);
        int need_r, need_c, free_c, new0, new1, t0, t1, pos;
        bit exp_ready, wr0, wr1;
        @(negedge clk);
        for (int l = 0; l < 2; l++) begin
            in_valid[l] = s_v[l]; in_has_dst[l] = s_d[l]; in_is_branch[l] = s_b[l];
            in_dst[l] = 4'(s_dst[l]); in_src_a[l] = 4'(s_sa[l]); in_src_b[l] = 4'(s_sb[l]);
        end
        res_valid = s_rv; res_tag = 2'(s_rt); res_mispredict = s_rm;
        #5;
        wr0 = s_v[0] && s_d[0];
        wr1 = s_v[1] && s_d[1];
        need_r = int'(wr0) + int'(wr1);
        need_c = int'(s_v[0] && s_b[0]) + int'(s_v[1] && s_b[1]);
        free_c = 0;
        for (int i = 0; i < NC; i++) if (!m_ck_v[i]) free_c++;
        exp_ready = !(s_rv && s_rm) && (POOL - m_ptr) >= need_r && free_c >= need_c;
        chk_eq(req, "ready", int'(ready), int'(exp_ready));
        if (exp_ready) begin
            new0 = NA + m_ptr;
            new1 = new0 + int'(wr0);
            t0 = lowest_free(-1);
            t1 = (s_v[0] && s_b[0]) ? lowest_free(t0) : t0;
            if (s_v[0]) begin
                chk_eq(req, "lane0 src_a", int'(out_src_a_phys[0]), m_map[s_sa[0]]);
                chk_eq(req, "lane0 src_b", int'(out_src_b_phys[0]), m_map[s_sb[0]]);
                chk_eq(req, "lane0 dst", int'(out_dst_phys[0]), wr0 ? new0 : 0);
                if (s_b[0]) chk_eq(req, "lane0 tag", int'(out_br_tag[0]), t0);
            end
            if (s_v[1]) begin
                chk_eq(req, "lane1 src_a", int'(out_src_a_phys[1]),
                       (wr0 && s_sa[1] == s_dst[0]) ? new0 : m_map[s_sa[1]]);
                chk_eq(req, "lane1 src_b", int'(out_src_b_phys[1]),
                       (wr0 && s_sb[1] == s_dst[0]) ? new0 : m_map[s_sb[1]]);
                chk_eq(req, "lane1 dst", int'(out_dst_phys[1]), wr1 ? new1 : 0);
                if (s_b[1]) chk_eq(req, "lane1 tag", int'(out_br_tag[1]), t1);
            end
            if (s_v[0]) begin
                if (wr0) begin m_map[s_dst[0]] = new0; m_ptr++; end
                if (s_b[0]) model_take(t0);
            end
            if (s_v[1]) begin
                if (wr1) begin m_map[s_dst[1]] = new1; m_ptr++; end
                if (s_b[1]) model_take(t1);
            end
        end
        if (s_rv && m_ck_v[s_rt]) begin
            pos = 0;
            for (int k = 0; k < m_order.size(); k++) if (m_order[k] == s_rt) pos = k;
            if (s_rm) begin
                for (int i = 0; i < NA; i++) m_map[i] = m_ck_map[s_rt][i];
                m_ptr = m_ck_ptr[s_rt];
                while (m_order.size() > pos) begin
                    m_ck_v[m_order[m_order.size()-1]] = 0;
                    void'(m_order.pop_back());
                end
            end else begin
                m_ck_v[s_rt] = 0;
                m_order.delete(pos);
            end
        end
        clear_stage();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = '0; in_has_dst = '0; in_is_branch = '0;
        res_valid = 1'b0; res_mispredict = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        clear_stage();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        clear_stage();
        model_reset();
        do_reset();

        // R1: identity map, empty checkpoints, ready high
        step("R1");
        for (int g = 0; g < 4; g++) begin
            set_lane(0, 0, 0, 4*g, 4*g+1, 0);
            set_lane(1, 0, 0, 4*g+2, 4*g+3, 0);
            step("R1");
        end
        set_lane(0, 1, 9, 9, 0, 0);
        step("R1");

        // R2: two writers of the same register in one group
        set_lane(0, 1, 3, 3, 3, 0);
        set_lane(1, 1, 3, 1, 2, 0);
        step("R2");
        // R3: newest copy is lane 1's
        set_lane(0, 0, 0, 3, 9, 0);
        step("R3");

        // R4: lane 1 reads lane 0's destination
        set_lane(0, 1, 5, 1, 5, 0);
        set_lane(1, 1, 6, 5, 5, 0);
        step("R4");
        set_lane(0, 0, 0, 5, 6, 0);
        set_lane(1, 1, 5, 6, 5, 0);
        step("R4");

        // R5: no destination takes nothing
        set_lane(0, 0, 2, 2, 4, 0);
        set_lane(1, 0, 7, 7, 8, 0);
        step("R5");
        set_lane(1, 1, 8, 8, 8, 0);
        step("R5");

        // R8: branch with own destination, then wrong-path writers
        set_lane(0, 1, 7, 7, 1, 1);
        set_lane(1, 1, 7, 7, 2, 0);
        step("R8");
        set_lane(0, 1, 1, 1, 7, 0);
        set_lane(1, 1, 2, 7, 1, 0);
        step("R8");
        // R10: mispredict cycle ignores the presented group
        set_lane(0, 1, 4, 4, 4, 0);
        set_res(m_order[0], 1);
        step("R10");
        set_lane(0, 1, 1, 7, 1, 0);
        set_lane(1, 0, 0, 2, 4, 0);
        step("R8");

        // R7: fill all slots, two branches per group
        set_lane(0, 1, 10, 1, 2, 1);
        set_lane(1, 0, 0, 10, 3, 1);
        step("R7");
        set_lane(0, 1, 11, 10, 2, 1);
        set_lane(1, 1, 12, 11, 3, 1);
        step("R7");
        set_lane(0, 0, 0, 12, 2, 1);
        step("R7");
        set_lane(1, 1, 13, 12, 11, 0);
        step("R7");

        // R9: mispredict the second oldest; two younger slots go too
        set_res(m_order[1], 1);
        step("R9");
        set_lane(0, 0, 0, 10, 11, 1);
        set_lane(1, 1, 14, 12, 13, 1);
        step("R9");
        set_lane(0, 0, 0, 14, 10, 1);
        set_lane(1, 0, 0, 11, 12, 0);
        step("R9");

        // R11: correct resolve together with renaming
        set_res(m_order[0], 0);
        set_lane(0, 1, 15, 14, 10, 0);
        step("R11");
        set_lane(0, 0, 0, 15, 14, 1);
        set_lane(1, 0, 0, 10, 11, 0);
        step("R11");

        // R6: drain the pool behind one checkpoint
        do_reset();
        set_lane(0, 0, 0, 0, 1, 1);
        step("R6");
        for (int k = 0; k < 15; k++) begin
            set_lane(0, 1, k, k, 15, 0);
            set_lane(1, 1, 15 - k, k, 3, 0);
            step("R6");
        end
        set_lane(0, 1, 4, 4, 5, 0);
        step("R6");
        set_lane(0, 1, 6, 4, 5, 0);
        set_lane(1, 1, 7, 6, 5, 0);
        step("R6");
        set_lane(0, 0, 0, 4, 6, 0);
        set_lane(1, 1, 8, 7, 4, 0);
        step("R6");
        set_lane(0, 1, 9, 8, 9, 0);
        step("R6");
        set_lane(0, 0, 0, 8, 9, 0);
        step("R6");
        set_res(m_order[0], 1);
        step("R8");
        set_lane(0, 1, 2, 8, 4, 0);
        set_lane(1, 0, 0, 15, 2, 0);
        step("R8");

        // R3: mixed traffic with branches and resolves
        for (int n = 0; n < 1500; n++) begin
            if (m_ptr >= 26 && m_order.size() == 0) begin
                do_reset();
            end
            for (int l = 0; l < 2; l++) begin
                if ($urandom % 4 != 0)
                    set_lane(l, ($urandom % 3) != 0, $urandom % 16, $urandom % 16,
                             $urandom % 16, ($urandom % 6) == 0);
            end
            if (m_ptr >= 26 && m_order.size() > 0) begin
                set_res(m_order[0], 1);
            end else if (m_order.size() > 0 && ($urandom % 3) == 0) begin
                set_res(m_order[$urandom % m_order.size()], ($urandom % 2) == 1);
            end
            step("R3");
        end

        done = 1;
        finish_run();
    end
endmodule